// File: doc/BRIEF.md
# Shared Bus Arbiter with Least-Recently-Used Option

This block decides which of up to sixteen initiators owns a shared on-chip peripheral bus. Every initiator has its own request line and its own grant line. The arbiter watches the bus select, lock and slave-acknowledge signals, and it moves ownership only in a cycle where a handover is legal. A handover is legal when the bus is idle, or in the final cycle of the current transfer, so that arbitration overlaps that cycle. When nobody is asking for the bus, the grant stays parked on the last owner.

A build parameter chooses the priority scheme. In fixed mode, each initiator has a priority level that a processor can read and write through a small register port. In dynamic mode, the arbiter keeps a true least-recently-used ordering. A second parameter chooses whether the grant lines come straight from the decision logic or from a register. The registered option costs one dead bus cycle but shortens the timing path. A transfer-length watchdog ends any transfer that no slave acknowledges in time.

Top module: `bus_arbiter`

## Requirements
- R1: After reset, exactly one bit of `grant` is high in every cycle.
- R2: After reset the grant is parked on master 0. In any arbitration cycle with no request pending, ownership stays with the previous owner.
- R3: Ownership changes only in an arbitration cycle. An arbitration cycle is one where `bus_select` is low, or `slave_ack` is high, or `timeout` is high.
- R4: Fixed mode (`LRU_MODE`=0). Each master has a level; a lower level means higher priority, and the lowest level among the requesters wins. Equal levels go to the lower master index. After reset, master i has level i. A write (`cfg_we` high) stores `cfg_wdata` as the level of master `cfg_addr`. `cfg_rdata` shows the current level of master `cfg_addr`.
- R5: Dynamic mode (`LRU_MODE`=1). Among the requesters, the master used least recently wins, and a granted master falls to the lowest priority. After reset, master 0 has the highest priority and master N-1 the lowest. `cfg_rdata` shows the rank of master `cfg_addr`, where 0 is the highest. Writes have no effect in this mode.
- R6: With `REG_GRANT`=0, the new grant appears in the arbitration cycle itself. With `REG_GRANT`=1, it appears one clock later.
- R7: `timeout` is high in the 16th consecutive cycle in which `bus_select` is high and `slave_ack` is low, and it ends the transfer. The count then restarts.
- R8: While `bus_lock` is high, the current owner keeps the grant, even in arbitration cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NUM_MASTERS | One request line per master |
| grant | output | NUM_MASTERS | One grant line per master, one-hot |
| bus_select | input | 1 | A transfer is in progress on the bus |
| bus_lock | input | 1 | Owner holds the bus across transfers |
| slave_ack | input | 1 | Slave completes the transfer this cycle |
| timeout | output | 1 | Transfer ended for lack of acknowledge |
| cfg_we | input | 1 | Write strobe for a priority level |
| cfg_addr | input | IDX_W | Master selected for level read or write |
| cfg_wdata | input | IDX_W | Level value to write |
| cfg_rdata | output | IDX_W | Level (fixed mode) or rank (dynamic mode) of the selected master |

## Verification
Two instances run side by side on the same stimulus: a fixed-priority one with combinational grants and a least-recently-used one with registered grants. A mixed request set while the bus is idle shows the level ordering and the one-cycle grant lag between the two. Holding all requests high while the bus is idle makes the dynamic instance rotate while the fixed instance stays put. Long transfers with no acknowledge, held locks, and levels rewritten to force ties bring out the watchdog, the lock, and the lower-index tie rule. A long pseudo-random run of requests, select, acknowledge, lock and writes then checks, cycle by cycle, that ownership moves only in legal cycles.

// File: rtl/arb_pkg.sv
`timescale 1ns/1ps
package arb_pkg;
  localparam int MAX_M = 16;
  localparam int KEY_W = 4;
  typedef logic [KEY_W-1:0] key_t;

  // Lowest key among requesters wins; strict compare keeps lower index on ties.
  function automatic key_t pick_winner(input logic [MAX_M-1:0] rq,
                                       input key_t keys [MAX_M]);
    key_t best_k;
    key_t best_i;
    logic found;
    best_k = '1;
    best_i = '0;
    found  = 1'b0;
    for (int i = 0; i < MAX_M; i++) begin
      if (rq[i] && (!found || keys[i] < best_k)) begin
        found  = 1'b1;
        best_k = keys[i];
        best_i = key_t'(i);
      end
    end
    return best_i;
  endfunction

  // Rank update for least-recently-used ordering (0 = highest priority).
  function automatic key_t next_rank(input key_t cur, input key_t win_rank,
                                     input logic is_win, input key_t bottom);
    if (is_win)
      return bottom;
    else if (cur > win_rank)
      return cur - key_t'(1);
    else
      return cur;
  endfunction
endpackage

// File: rtl/prio_regs.sv
`timescale 1ns/1ps
module prio_regs
  import arb_pkg::*;
#(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [IDX_W-1:0] wr_val,
  output key_t             level [N]
);
  for (genvar i = 0; i < N; i++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (!rst_n)
        level[i] <= key_t'(i);
      else if (wr_en && wr_idx == IDX_W'(i))
        level[i] <= key_t'(wr_val);
    end
  end
endmodule

// File: rtl/lru_ranks.sv
`timescale 1ns/1ps
module lru_ranks
  import arb_pkg::*;
#(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [IDX_W-1:0] win,
  output key_t             rank [N]
);
  localparam key_t BOTTOM = key_t'(N - 1);
  key_t win_rank;
  assign win_rank = rank[win];

  for (genvar i = 0; i < N; i++) begin : g_rank
    always_ff @(posedge clk) begin
      if (!rst_n)
        rank[i] <= key_t'(i);
      else if (upd)
        rank[i] <= next_rank(rank[i], win_rank, win == IDX_W'(i), BOTTOM);
    end
  end
endmodule

// File: rtl/xfer_timer.sv
`timescale 1ns/1ps
module xfer_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic ack,
  output logic expire
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  logic [CNT_W-1:0] cnt;

  assign expire = sel && !ack && (cnt == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (!sel || ack || expire)
      cnt <= '0;
    else
      cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/bus_arbiter.sv
`timescale 1ns/1ps
module bus_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_MASTERS    = 4,
  parameter bit LRU_MODE       = 1'b0,
  parameter bit REG_GRANT      = 1'b0,
  parameter int TIMEOUT_CYCLES = 16,
  localparam int IDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] req,
  output logic [NUM_MASTERS-1:0] grant,
  input  logic                   bus_select,
  input  logic                   bus_lock,
  input  logic                   slave_ack,
  output logic                   timeout,
  input  logic                   cfg_we,
  input  logic [IDX_W-1:0]       cfg_addr,
  input  logic [IDX_W-1:0]       cfg_wdata,
  output logic [IDX_W-1:0]       cfg_rdata
);
  // Named internal events for the checker.
  logic             arb_cycle;
  logic             arb_win;
  logic [IDX_W-1:0] owner_q;
  logic [IDX_W-1:0] next_owner;
  logic [IDX_W-1:0] winner_idx;
  key_t             keys      [NUM_MASTERS];
  key_t             keys_full [MAX_M];
  logic [MAX_M-1:0] req_full;

  xfer_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .sel(bus_select), .ack(slave_ack), .expire(timeout)
  );

  assign arb_cycle = !bus_select || slave_ack || timeout;
  assign arb_win   = arb_cycle && !bus_lock && (|req);

  if (LRU_MODE) begin : g_lru
    lru_ranks #(.N(NUM_MASTERS), .IDX_W(IDX_W)) u_ranks (
      .clk(clk), .rst_n(rst_n), .upd(arb_win), .win(winner_idx), .rank(keys)
    );
  end else begin : g_fixed
    prio_regs #(.N(NUM_MASTERS), .IDX_W(IDX_W)) u_levels (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_idx(cfg_addr),
      .wr_val(cfg_wdata), .level(keys)
    );
  end

  assign cfg_rdata = IDX_W'(keys[cfg_addr]);

  for (genvar i = 0; i < MAX_M; i++) begin : g_pad
    if (i < NUM_MASTERS) begin : g_real
      assign keys_full[i] = keys[i];
    end else begin : g_none
      assign keys_full[i] = '1;
    end
  end
  assign req_full = MAX_M'(req);

  assign winner_idx = IDX_W'(pick_winner(req_full, keys_full));
  assign next_owner = arb_win ? winner_idx : owner_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      owner_q <= '0;
    else
      owner_q <= next_owner;
  end

  for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_gnt
    if (REG_GRANT) begin : g_reg
      assign grant[i] = (owner_q == IDX_W'(i));
    end else begin : g_comb
      assign grant[i] = (next_owner == IDX_W'(i));
    end
  end
endmodule

// File: rtl/bus_arbiter_chk.sv
`timescale 1ns/1ps
module bus_arbiter_chk #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N-1:0]     req,
  input logic [N-1:0]     grant,
  input logic             bus_select,
  input logic             slave_ack,
  input logic             bus_lock,
  input logic             timeout,
  input logic             arb_cycle,
  input logic [IDX_W-1:0] owner
);
  a_r1_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) == 1);

  a_r2_park_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> $stable(owner));

  a_r3_hold_outside_arb: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_cycle |=> $stable(owner));

  a_r8_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    bus_lock |=> $stable(owner));

  a_r7_timeout_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (bus_select && !slave_ack));

  a_r7_timeout_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout);
endmodule

bind bus_arbiter bus_arbiter_chk #(.N(NUM_MASTERS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .grant(grant), .bus_select(bus_select),
  .slave_ack(slave_ack), .bus_lock(bus_lock), .timeout(timeout),
  .arb_cycle(arb_cycle), .owner(owner_q)
);

// File: tb/tb_bus_arbiter.sv
`timescale 1ns/1ps
module tb_bus_arbiter;
  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = '0;
  logic       sel = 1'b0, lock = 1'b0, ack = 1'b0, we = 1'b0;
  logic [1:0] addr = '0, wdata = '0;
  logic [3:0] gf, gl;
  logic       tof, tol;
  logic [1:0] rdf, rdl;

  always #4 clk = ~clk;  // 125 MHz

  bus_arbiter #(.NUM_MASTERS(N), .LRU_MODE(1'b0), .REG_GRANT(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .grant(gf), .bus_select(sel),
    .bus_lock(lock), .slave_ack(ack), .timeout(tof), .cfg_we(we),
    .cfg_addr(addr), .cfg_wdata(wdata), .cfg_rdata(rdf));

  bus_arbiter #(.NUM_MASTERS(N), .LRU_MODE(1'b1), .REG_GRANT(1'b1)) dut_lru (
    .clk(clk), .rst_n(rst_n), .req(req), .grant(gl), .bus_select(sel),
    .bus_lock(lock), .slave_ack(ack), .timeout(tol), .cfg_we(we),
    .cfg_addr(addr), .cfg_wdata(wdata), .cfg_rdata(rdl));

  typedef struct {
    logic [3:0] gf, gl;
    logic       to;
    logic [1:0] rf, rl;
    string      tag;
  } exp_t;
  exp_t sb[$];

  // Bench model state
  int m_lvl [4];
  int order [4];   // order[0] = most deserving in dynamic mode
  int f_own, l_own, cnt;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%b exp=%b", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] r, input logic s, input logic lk,
                      input logic a, input logic w, input logic [1:0] ad,
                      input logic [1:0] wd, input string tag);
    exp_t e;
    bit to_e, arb, win;
    int fw, lw, lp, pos;
    @(negedge clk);
    req = r; sel = s; lock = lk; ack = a; we = w; addr = ad; wdata = wd;
    to_e = s && !a && (cnt == 15);
    arb  = !s || a || to_e;
    win  = arb && !lk && (r != 4'b0);
    fw = -1;
    for (int lv = 0; lv < 4; lv++)
      for (int i = 0; i < 4; i++)
        if (fw < 0 && r[i] && m_lvl[i] == lv) fw = i;
    lw = -1; lp = 0;
    for (int p = 0; p < 4; p++)
      if (lw < 0 && r[order[p]]) begin lw = order[p]; lp = p; end
    pos = 0;
    for (int p = 0; p < 4; p++) if (order[p] == int'(ad)) pos = p;
    e.gf  = 4'b1 << (win ? fw : f_own);
    e.gl  = 4'b1 << l_own;
    e.to  = to_e;
    e.rf  = 2'(m_lvl[ad]);
    e.rl  = 2'(pos);
    e.tag = tag;
    sb.push_back(e);
    if (win) begin
      f_own = fw;
      l_own = lw;
      for (int p = lp; p < 3; p++) order[p] = order[p + 1];
      order[3] = lw;
    end
    cnt = (!s || a || to_e) ? 0 : cnt + 1;
    if (w) m_lvl[ad] = int'(wd);
  endtask

  // Monitor / scoreboard
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #2;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        chk(gf == e.gf, e.tag, "grant fixed/comb", gf, e.gf);
        chk(gl == e.gl, e.tag, "grant lru/reg", gl, e.gl);
        chk($countones(gf) == 1, "R1", "one-hot fixed", gf, 4'b0);
        chk($countones(gl) == 1, "R1", "one-hot lru", gl, 4'b0);
        chk(tof == e.to && tol == e.to, e.tag, "R7 timeout",
            {2'b0, tof, tol}, {2'b0, e.to, e.to});
        chk(rdf == e.rf, e.tag, "R4 level readback", {2'b0, rdf}, {2'b0, e.rf});
        chk(rdl == e.rl, e.tag, "R5 rank readback", {2'b0, rdl}, {2'b0, e.rl});
      end
    end
  end

  // Watchdog
  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < 4; i++) begin m_lvl[i] = i; order[i] = i; end
    f_own = 0; l_own = 0; cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R2: reset parking on master 0
    repeat (2) step(4'b0000, 0, 0, 0, 0, 2'd0, 2'd0, "R2 reset park");
    // R4 / R6: level order while idle, comb vs registered lag
    repeat (2) step(4'b1110, 0, 0, 0, 0, 2'd1, 2'd0, "R4 R6 idle mixed");
    // R3: hold during transfer, hand over on ack
    repeat (3) step(4'b1100, 1, 0, 0, 0, 2'd2, 2'd0, "R3 hold in xfer");
    step(4'b1100, 1, 0, 1, 0, 2'd3, 2'd0, "R3 overlapped handoff");
    repeat (2) step(4'b0000, 0, 0, 0, 0, 2'd0, 2'd0, "R2 park on last owner");
    // R4 / R5: write levels; dynamic instance ignores them
    step(4'b0000, 0, 0, 0, 1, 2'd3, 2'd0, "R4 write m3");
    step(4'b0000, 0, 0, 0, 1, 2'd1, 2'd0, "R4 write m1");
    step(4'b0000, 0, 0, 0, 0, 2'd3, 2'd0, "R4 R5 readback m3");
    step(4'b0000, 0, 0, 0, 0, 2'd1, 2'd0, "R4 R5 readback m1");
    repeat (2) step(4'b1010, 0, 0, 0, 0, 2'd0, 2'd0, "R4 tie lower index");
    // R8: lock keeps owner through idle cycles
    repeat (3) step(4'b0100, 0, 1, 0, 0, 2'd2, 2'd0, "R8 lock holds");
    repeat (2) step(4'b0100, 0, 0, 0, 0, 2'd2, 2'd0, "R8 lock release");
    // R7: long transfer without ack
    repeat (20) step(4'b1001, 1, 0, 0, 0, 2'd0, 2'd0, "R7 timeout");
    step(4'b0000, 0, 0, 0, 0, 2'd0, 2'd0, "R7 idle after");
    // R5: rotation with all requesting
    repeat (8) step(4'b1111, 0, 0, 0, 0, 2'd2, 2'd0, "R5 rotation");
    repeat (3) step(4'b0011, 0, 0, 0, 0, 2'd0, 2'd0, "R5 pair 0/1");
    repeat (3) step(4'b0101, 0, 0, 0, 0, 2'd3, 2'd0, "R5 pair 0/2");
    // R1 / R3: pseudo-random mix
    lf = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[3:0], lf[5], lf[9:7] == 3'b000, lf[6] & lf[4],
           lf[11] & lf[12] & lf[13], lf[15:14], lf[2:1], "R1 R3 random mix");
    end

    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule